// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit with Condition Flags

This block moves an 8-bit or 16-bit operand by exactly one bit position and produces four condition flags: negative, zero, overflow and carry. It has five operations. A left shift serves as both the logical and the arithmetic form. A logical right shift fills the top bit with zero. An arithmetic right shift keeps the sign. Two rotates pass through the carry: the incoming carry enters at one end, and the bit that drops out at the other end becomes the new carry.

The unit is purely combinational. An execution stage places it next to its adder and drives the operand, a width select, a 3-bit operation code and the current carry. It reads back the result and the flags in the same cycle. There is no stream interface, because nothing is queued or held. All pins are plain control and data signals. The overflow flag reports that the sign bit and the carry disagree after the move. For left shifts and left rotates, this means the sign bit changed.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 (left shift) returns the operand shifted toward the MSB with 0 entering bit 0; C takes the old MSB of the active width.
- R2: Operation code 1 (logical right shift) returns the operand shifted toward bit 0 with 0 entering the active MSB; C takes the old bit 0.
- R3: Operation code 2 (arithmetic right shift) shifts toward bit 0 while the active MSB keeps its old value; C takes the old bit 0.
- R4: Operation code 3 (rotate left through carry) places the incoming carry in bit 0, shifts the rest toward the MSB, and puts the old active MSB in C.
- R5: Operation code 4 (rotate right through carry) places the incoming carry in the active MSB, shifts the rest toward bit 0, and puts the old bit 0 in C.
- R6: Operation codes 5, 6 and 7 pass the active-width operand through unchanged, and C equals the incoming carry.
- R7: N equals the MSB of the active-width result (bit 7 in byte mode, bit 15 in word mode). Z is 1 exactly when the whole 16-bit result is zero.
- R8: V equals N xor C for every operation code. After a left shift or left rotate, this is 1 exactly when the active MSB changed.
- R9: A width select of 0 chooses byte mode: operand bits 15..8 have no effect, and result bits 15..8 are 0. A width select of 1 chooses word mode over all 16 bits.
- R10: The unit is combinational. Result and flags follow the inputs without a clock, and all-zero inputs give a zero result with Z=1 and N=V=C=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 16 | Operand; only bits 7..0 are used in byte mode |
| wide_i | input | 1 | Width select: 0 byte, 1 word |
| op_i | input | 3 | Operation code (0 left shift, 1 logical right, 2 arithmetic right, 3 rotate left, 4 rotate right) |
| c_i | input | 1 | Incoming carry flag |
| res_o | output | 16 | Result, zero-extended in byte mode |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag (N xor C) |
| c_o | output | 1 | Carry flag out |

## Verification
The bench builds the unit with its default parameters: a 16-bit word lane and an 8-bit byte lane. With these values, the sign and carry positions sit at bit 7 in one mode and bit 15 in the other. Directed patterns can then show that each flag follows the active MSB. They can also show that noise on the upper operand byte never reaches a byte-mode result. Sign-edge values (0x80, 0x8000, 0x01, 0x0001) and a pseudo-random sweep over every operation code in both widths cover the carry paths, the sign-change rule and the unused codes.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4
  } shrot_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } shrot_flags_t;

endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] opnd_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);

  localparam int MSB = W - 1;

  always_comb begin
    res_o  = opnd_i;
    cout_o = cin_i;
    case (op_i)
      OP_SHL: begin
        res_o  = {opnd_i[MSB-1:0], 1'b0};
        cout_o = opnd_i[MSB];
      end
      OP_LSR: begin
        res_o  = {1'b0, opnd_i[MSB:1]};
        cout_o = opnd_i[0];
      end
      OP_ASR: begin
        res_o  = {opnd_i[MSB], opnd_i[MSB:1]};
        cout_o = opnd_i[0];
      end
      OP_ROL: begin
        res_o  = {opnd_i[MSB-1:0], cin_i};
        cout_o = opnd_i[MSB];
      end
      OP_ROR: begin
        res_o  = {cin_i, opnd_i[MSB:1]};
        cout_o = opnd_i[0];
      end
      default: begin
        res_o  = opnd_i;
        cout_o = cin_i;
      end
    endcase
  end

  // Lane-level checks on the moved bits
  always_comb begin
    if (op_i == OP_LSR)
      a_r2_lsr_top_zero: assert (res_o[MSB] == 1'b0 && cout_o == opnd_i[0]);
    if (op_i == OP_ASR)
      a_r3_asr_keeps_sign: assert (res_o[MSB] == opnd_i[MSB]);
    if (op_i == OP_ROL)
      a_r4_rol_cin_enters: assert (res_o[0] == cin_i && cout_o == opnd_i[MSB]);
    if (op_i == OP_ROR)
      a_r5_ror_cin_enters: assert (res_o[MSB] == cin_i && cout_o == opnd_i[0]);
    if (op_i > 3'd4)
      a_r6_unused_passthru: assert (res_o == opnd_i && cout_o == cin_i);
  end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
#(
  parameter int WW = 16,
  parameter int NW = 8
) (
  input  logic          wide_i,
  input  logic [WW-1:0] res_i,
  input  logic          c_i,
  output shrot_flags_t  flg_o
);

  always_comb begin
    flg_o.n = wide_i ? res_i[WW-1] : res_i[NW-1];
    flg_o.z = (res_i == '0);
    flg_o.c = c_i;
    flg_o.v = flg_o.n ^ c_i;
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [WIDE_W-1:0] opnd_i,
  input  logic              wide_i,
  input  logic [2:0]        op_i,
  input  logic              c_i,
  output logic [WIDE_W-1:0] res_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o
);

  localparam int PAD_W = WIDE_W - NARROW_W;

  logic [WIDE_W-1:0]   wide_res;
  logic                wide_c;
  logic [NARROW_W-1:0] nar_res;
  logic                nar_c;
  logic                sel_c;
  shrot_flags_t        flg;

  shrot_lane #(.W(WIDE_W)) u_wide (
    .op_i   (op_i),
    .opnd_i (opnd_i),
    .cin_i  (c_i),
    .res_o  (wide_res),
    .cout_o (wide_c)
  );

  shrot_lane #(.W(NARROW_W)) u_narrow (
    .op_i   (op_i),
    .opnd_i (opnd_i[NARROW_W-1:0]),
    .cin_i  (c_i),
    .res_o  (nar_res),
    .cout_o (nar_c)
  );

  always_comb begin
    res_o = wide_i ? wide_res : {{PAD_W{1'b0}}, nar_res};
    sel_c = wide_i ? wide_c : nar_c;
  end

  shrot_flags #(.WW(WIDE_W), .NW(NARROW_W)) u_flags (
    .wide_i (wide_i),
    .res_i  (res_o),
    .c_i    (sel_c),
    .flg_o  (flg)
  );

  assign n_o = flg.n;
  assign z_o = flg.z;
  assign v_o = flg.v;
  assign c_o = flg.c;

  // Top-level checks relating operand, result and flags
  always_comb begin
    if (!wide_i)
      a_r9_byte_upper_zero: assert (res_o[WIDE_W-1:NARROW_W] == '0);
    a_r7_zero_flag: assert (z_o == (res_o == '0));
    a_r7_neg_flag: assert (n_o == (wide_i ? res_o[WIDE_W-1] : res_o[NARROW_W-1]));
    if (op_i == OP_SHL && wide_i)
      a_r1_shl_word: assert (res_o == {opnd_i[WIDE_W-2:0], 1'b0} && c_o == opnd_i[WIDE_W-1]);
    if ((op_i == OP_SHL || op_i == OP_ROL) && !wide_i)
      a_r8_sign_change_byte: assert (v_o == (res_o[NARROW_W-1] ^ opnd_i[NARROW_W-1]));
    if ((op_i == OP_SHL || op_i == OP_ROL) && wide_i)
      a_r8_sign_change_word: assert (v_o == (res_o[WIDE_W-1] ^ opnd_i[WIDE_W-1]));
  end

endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;

  logic        clk;
  logic        rst_n;
  logic [15:0] opnd;
  logic        wide;
  logic [2:0]  op;
  logic        cin;
  logic [15:0] res;
  logic        n, z, v, c;
  int          n_checks;
  int          n_fails;
  logic        done;

  shrot_unit u_dut (
    .opnd_i (opnd),
    .wide_i (wide),
    .op_i   (op),
    .c_i    (cin),
    .res_o  (res),
    .n_o    (n),
    .z_o    (z),
    .v_o    (v),
    .c_o    (c)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected {n,z,v,c,res} built from the requirement text
  function automatic logic [19:0] model(input logic [2:0] o, input logic wd,
                                        input logic [15:0] a, input logic ci);
    logic [15:0] x, r;
    logic        cc, top, nn, zz;
    int          m;
    m   = wd ? 15 : 7;
    x   = wd ? a : {8'h00, a[7:0]};
    top = x[m];
    r   = x;
    cc  = ci;
    case (o)
      3'd0: begin r = x * 2; cc = top; end
      3'd1: begin r = x / 2; cc = x[0]; end
      3'd2: begin r = x / 2; r[m] = top; cc = x[0]; end
      3'd3: begin r = x * 2; r[0] = ci; cc = top; end
      3'd4: begin r = x / 2; r[m] = ci; cc = x[0]; end
      default: begin r = x; cc = ci; end
    endcase
    if (!wd) r[15:8] = 8'h00;
    nn = r[m];
    zz = (r == 16'h0000);
    return {nn, zz, nn ^ cc, cc, r};
  endfunction

  task automatic apply_check(input logic [2:0] o, input logic wd, input logic [15:0] a,
                             input logic ci, input string tag);
    logic [19:0] exp, got;
    @(negedge clk);
    op = o; wide = wd; opnd = a; cin = ci;
    #1;
    exp = model(o, wd, a, ci);
    got = {n, z, v, c, res};
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s op=%0d wide=%0b opnd=%h cin=%0b actual nzvc=%b res=%h expected nzvc=%b res=%h",
               tag, o, wd, a, ci, got[19:16], got[15:0], exp[19:16], exp[15:0]);
    end
  endtask

  task automatic t_idle_state();
    @(negedge clk);
    op = 3'd0; wide = 1'b0; opnd = 16'h0000; cin = 1'b0;
    #1;
    n_checks++;
    if ({n, z, v, c, res} !== {4'b0100, 16'h0000}) begin
      n_fails++;
      $display("FAIL R10 idle actual nzvc=%b res=%h expected nzvc=0100 res=0000",
               {n, z, v, c}, res);
    end
  endtask

  task automatic t_shift_left();
    apply_check(3'd0, 1'b0, 16'h0080, 1'b1, "R1 byte sign out, R7 zero, R8");
    apply_check(3'd0, 1'b0, 16'h0040, 1'b0, "R1 byte into sign, R8");
    apply_check(3'd0, 1'b1, 16'h8000, 1'b0, "R1 word sign out");
    apply_check(3'd0, 1'b1, 16'h4001, 1'b1, "R1 word cin ignored");
  endtask

  task automatic t_logical_right();
    apply_check(3'd1, 1'b0, 16'h0081, 1'b1, "R2 byte");
    apply_check(3'd1, 1'b1, 16'h8001, 1'b1, "R2 word");
    apply_check(3'd1, 1'b1, 16'h0001, 1'b0, "R2 word to zero, R7");
  endtask

  task automatic t_arith_right();
    apply_check(3'd2, 1'b0, 16'h0081, 1'b0, "R3 byte negative");
    apply_check(3'd2, 1'b1, 16'h8000, 1'b1, "R3 word negative");
    apply_check(3'd2, 1'b1, 16'h7FFF, 1'b0, "R3 word positive");
  endtask

  task automatic t_rotates();
    apply_check(3'd3, 1'b0, 16'h0080, 1'b1, "R4 byte");
    apply_check(3'd3, 1'b1, 16'h8000, 1'b0, "R4 word to zero");
    apply_check(3'd3, 1'b1, 16'h4000, 1'b1, "R4 word sign change, R8");
    apply_check(3'd4, 1'b0, 16'h0001, 1'b1, "R5 byte");
    apply_check(3'd4, 1'b1, 16'h0001, 1'b0, "R5 word to zero");
    apply_check(3'd4, 1'b1, 16'h0002, 1'b1, "R5 word cin to msb");
  endtask

  task automatic t_unused_codes();
    apply_check(3'd5, 1'b1, 16'hA55A, 1'b1, "R6 code5");
    apply_check(3'd6, 1'b0, 16'hFF80, 1'b0, "R6 code6 byte");
    apply_check(3'd7, 1'b1, 16'h0000, 1'b1, "R6 code7");
  endtask

  task automatic t_width_select();
    for (int k = 0; k < 5; k++) begin
      apply_check(3'(k), 1'b0, 16'hFF00, 1'b1, "R9 upper byte ignored");
      apply_check(3'(k), 1'b0, 16'h5A00, 1'b0, "R9 upper byte ignored, R7 zero");
    end
  endtask

  task automatic t_sweep();
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      apply_check(3'(i % 8), i[3], lf, lf[4], "R8 R10 sweep");
    end
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    op = 3'd0; wide = 1'b0; opnd = 16'h0000; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle_state();
    t_shift_left();
    t_logical_right();
    t_arith_right();
    t_rotates();
    t_unused_codes();
    t_width_select();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule